// File: doc/BRIEF.md
# Boost Over-Time Fault Accumulator

This block watches a one-bit overvoltage comparator on the boost output and decides whether the voltage has stayed too high for too long. On every pulse of a periodic sample strobe (nominally one every 20 µs), it takes one sample of the comparator bit. Over a fixed observation window it counts how many samples were high. When that count goes above a programmable on-time limit, it raises a fault flag. The flag stays latched until the block is disabled or reset.

The limit is linear in a 7-bit code and includes an offset. The window length is either short (nominally 1 s, 50 000 samples) or long (nominally 2 s, 100 000 samples), picked by a select bit. The limit scales with the window that is chosen. The protection runs only while its disable input is low. Driving that input high clears all state.

Top module: `boost_ot_accum`

## Requirements
- R1: After a synchronous reset, `fault_o` is 0 and `hit_count_o` is 0.
- R2: While `prot_dis_i` is 1, `hit_count_o` is 0 and `fault_o` is 0 one cycle later, whatever the strobe and comparator inputs do, and a latched fault is cleared. Each 1→0 transition of `prot_dis_i` starts a fresh window.
- R3: `hit_count_o` grows by exactly one for each cycle with `sample_stb_i`=1 and `cmp_hi_i`=1. It does not change on cycles where the strobe is low or the comparator is low (except at a window end).
- R4: With `win_long_i`=0 the limit is `thr_code_i`×256+128 samples. A count equal to the limit gives no fault. The strobe that brings the count to limit+1 sets `fault_o` on the next cycle.
- R5: With `win_long_i`=1 the limit is `thr_code_i`×512+256 samples, with the same exceed rule as R4.
- R6: With `win_long_i`=0 a window is `WIN_SHORT` strobes (high or low). After the last strobe of a window, `hit_count_o` is 0.
- R7: With `win_long_i`=1 a window is `WIN_LONG` strobes. The count is not cleared at `WIN_SHORT` strobes.
- R8: Once set, `fault_o` stays 1 across window ends until reset or disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_dis_i | input | 1 | 1 disables the protection and clears state; 0 enables it |
| sample_stb_i | input | 1 | One-cycle pulse marking a comparator sample |
| cmp_hi_i | input | 1 | Comparator bit, 1 when the boost voltage is above its threshold |
| win_long_i | input | 1 | Window select: 0 short, 1 long |
| thr_code_i | input | 7 | On-time limit code |
| fault_o | output | 1 | Latched over-time fault |
| hit_count_o | output | CNT_W | High samples counted in the current window |

## Verification
Some behaviours are checked by assertions on every cycle. These are the clearing effect of the disable input, the one-per-strobe growth of the count and its stability between strobes, the window counter never reaching its length, and the fault staying latched while enabled. Other behaviours can only be shown by the bench's scenarios. These are the exact limit arithmetic in both modes (no fault at the limit, a fault one sample past it), the window lengths in both modes, and the fault surviving a window end. The bench shortens the windows through parameters so that full windows fit in a short run.

// File: rtl/boc_pkg.sv
package boc_pkg;

    localparam int CODE_W        = 7;
    localparam int LIM_STEP_1X   = 256;
    localparam int LIM_OFS_1X    = 128;

    typedef enum logic {
        WIN_1X = 1'b0,
        WIN_2X = 1'b1
    } win_mode_e;

    typedef struct packed {
        logic stb;
        logic hi;
    } boc_sample_t;

    // On-time limit in samples; the long window doubles step and offset.
    function automatic logic [31:0] on_limit(input logic [CODE_W-1:0] code,
                                             input win_mode_e mode);
        logic [31:0] base;
        base = 32'(code) * 32'(LIM_STEP_1X) + 32'(LIM_OFS_1X);
        return (mode == WIN_2X) ? (base << 1) : base;
    endfunction

endpackage

// File: rtl/boc_window_ctr.sv
module boc_window_ctr
    import boc_pkg::*;
#(
    parameter int WIN_SHORT = 50000,
    parameter int WIN_LONG  = 100000,
    parameter int CNT_W     = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             stb,
    input  win_mode_e        mode,
    output logic             win_end
);
    localparam logic [CNT_W-1:0] LAST_1X = CNT_W'(WIN_SHORT - 1);
    localparam logic [CNT_W-1:0] LAST_2X = CNT_W'(WIN_LONG - 1);

    logic [CNT_W-1:0] win_cnt;
    logic [CNT_W-1:0] last_idx;

    assign last_idx = (mode == WIN_2X) ? LAST_2X : LAST_1X;
    assign win_end  = stb && (win_cnt >= last_idx);

    always_ff @(posedge clk) begin
        if (rst || clr)   win_cnt <= '0;
        else if (win_end) win_cnt <= '0;
        else if (stb)     win_cnt <= win_cnt + 1'b1;
    end

    a_r6_win_bound: assert property (@(posedge clk) disable iff (rst)
        win_cnt <= LAST_2X);

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr && !stb) |=> $stable(win_cnt));

endmodule

// File: rtl/boc_hit_ctr.sv
module boc_hit_ctr
    import boc_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  boc_sample_t      smp,
    input  logic             win_end,
    output logic [CNT_W-1:0] hit_cnt,
    output logic [CNT_W-1:0] hit_next
);
    assign hit_next = hit_cnt + CNT_W'(smp.stb && smp.hi);

    always_ff @(posedge clk) begin
        if (rst || clr)   hit_cnt <= '0;
        else if (win_end) hit_cnt <= '0;
        else if (smp.stb) hit_cnt <= hit_next;
    end

    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!clr && !smp.stb) |=> $stable(hit_cnt));

    a_r3_step_one: assert property (@(posedge clk) disable iff (rst)
        (!clr && smp.stb && smp.hi && !win_end) |=> (hit_cnt == $past(hit_cnt) + 1'b1));

    a_r6_clear_at_end: assert property (@(posedge clk) disable iff (rst)
        win_end |=> (hit_cnt == '0));

endmodule

// File: rtl/boc_fault_latch.sv
module boc_fault_latch
    import boc_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             stb,
    input  logic [CNT_W-1:0] hit_next,
    input  logic [31:0]      limit,
    output logic             fault
);
    logic over;
    assign over = stb && (32'(hit_next) > limit);

    always_ff @(posedge clk) begin
        if (rst || clr) fault <= 1'b0;
        else if (over)  fault <= 1'b1;
    end

    a_r8_latched: assert property (@(posedge clk) disable iff (rst)
        (fault && !clr) |=> fault);

    a_r4_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(fault) |-> $past(over));

endmodule

// File: rtl/boost_ot_accum.sv
module boost_ot_accum
    import boc_pkg::*;
#(
    parameter int WIN_SHORT = 50000,
    parameter int WIN_LONG  = 100000,
    parameter int CNT_W     = $clog2(WIN_LONG + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  prot_dis_i,
    input  logic                  sample_stb_i,
    input  logic                  cmp_hi_i,
    input  logic                  win_long_i,
    input  logic [CODE_W-1:0]     thr_code_i,
    output logic                  fault_o,
    output logic [CNT_W-1:0]      hit_count_o
);
    boc_sample_t      smp;
    win_mode_e        mode;
    logic             win_end;
    logic [CNT_W-1:0] hit_next;
    logic [31:0]      limit;

    assign smp.stb = sample_stb_i && !prot_dis_i;
    assign smp.hi  = cmp_hi_i;
    assign mode    = win_long_i ? WIN_2X : WIN_1X;
    assign limit   = on_limit(thr_code_i, mode);

    boc_window_ctr #(
        .WIN_SHORT (WIN_SHORT),
        .WIN_LONG  (WIN_LONG),
        .CNT_W     (CNT_W)
    ) win_i (
        .clk     (clk),
        .rst     (rst),
        .clr     (prot_dis_i),
        .stb     (smp.stb),
        .mode    (mode),
        .win_end (win_end)
    );

    boc_hit_ctr #(
        .CNT_W (CNT_W)
    ) hit_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (prot_dis_i),
        .smp      (smp),
        .win_end  (win_end),
        .hit_cnt  (hit_count_o),
        .hit_next (hit_next)
    );

    boc_fault_latch #(
        .CNT_W (CNT_W)
    ) flt_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (prot_dis_i),
        .stb      (smp.stb),
        .hit_next (hit_next),
        .limit    (limit),
        .fault    (fault_o)
    );

    a_r2_disabled_clear: assert property (@(posedge clk) disable iff (rst)
        prot_dis_i |=> (!fault_o && hit_count_o == '0));

endmodule

// File: tb/boost_ot_accum_tb.sv
`timescale 1ns/1ps
module boost_ot_accum_tb_top;

    localparam int WS = 1000;
    localparam int WL = 2000;
    localparam int CW = $clog2(WL + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          prot_dis = 1'b0;
    logic          stb = 1'b0;
    logic          hi = 1'b0;
    logic          wlong = 1'b0;
    logic [6:0]    code = '0;
    logic          fault;
    logic [CW-1:0] cnt;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    boost_ot_accum #(.WIN_SHORT(WS), .WIN_LONG(WL)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .prot_dis_i   (prot_dis),
        .sample_stb_i (stb),
        .cmp_hi_i     (hi),
        .win_long_i   (wlong),
        .thr_code_i   (code),
        .fault_o      (fault),
        .hit_count_o  (cnt)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Apply n cycles of (strobe, comparator); returns at a negedge with outputs settled.
    task automatic drive(input logic s, input logic h, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            stb = s;
            hi  = h;
        end
        @(negedge clk);
        stb = 1'b0;
        hi  = 1'b0;
    endtask

    task automatic restart(input logic lng, input logic [6:0] c);
        @(negedge clk);
        prot_dis = 1'b1;
        wlong    = lng;
        code     = c;
        @(negedge clk);
        prot_dis = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 fault after reset", int'(fault), 0);
        chk("R1 count after reset", int'(cnt), 0);
    endtask

    task automatic t_count;
        restart(1'b0, 7'd3);
        drive(1'b1, 1'b1, 10);
        chk("R3 ten high strobes", int'(cnt), 10);
        drive(1'b1, 1'b0, 5);
        chk("R3 low strobes ignored", int'(cnt), 10);
        drive(1'b0, 1'b1, 3);
        chk("R3 high without strobe ignored", int'(cnt), 10);
    endtask

    task automatic t_short_limit;
        restart(1'b0, 7'd0);           // limit 128
        drive(1'b1, 1'b1, 128);
        chk("R4 count at limit", int'(cnt), 128);
        chk("R4 no fault at limit", int'(fault), 0);
        drive(1'b1, 1'b1, 1);
        chk("R4 fault past limit", int'(fault), 1);
    endtask

    task automatic t_long_limit;
        restart(1'b1, 7'd1);           // limit 768
        drive(1'b1, 1'b1, 768);
        chk("R5 no fault at limit", int'(fault), 0);
        drive(1'b1, 1'b1, 1);
        chk("R5 fault past limit", int'(fault), 1);
    endtask

    task automatic t_short_window;
        restart(1'b0, 7'd3);           // limit 896
        drive(1'b1, 1'b1, 500);
        drive(1'b1, 1'b0, WS - 501);
        chk("R6 count before window end", int'(cnt), 500);
        drive(1'b1, 1'b1, 1);
        chk("R6 count cleared at window end", int'(cnt), 0);
        chk("R6 no fault below limit", int'(fault), 0);
    endtask

    task automatic t_long_window;
        restart(1'b1, 7'd5);           // limit 2816, beyond window
        drive(1'b1, 1'b1, WS);
        chk("R7 no clear at short length", int'(cnt), WS);
        drive(1'b1, 1'b1, WL - WS - 1);
        chk("R7 count before long end", int'(cnt), WL - 1);
        drive(1'b1, 1'b1, 1);
        chk("R7 count cleared at long end", int'(cnt), 0);
    endtask

    task automatic t_latch_and_disable;
        restart(1'b0, 7'd0);
        drive(1'b1, 1'b1, 129);
        chk("R4 fault set", int'(fault), 1);
        drive(1'b1, 1'b0, WS - 129);
        chk("R8 window ended", int'(cnt), 0);
        chk("R8 fault held over window end", int'(fault), 1);
        @(negedge clk);
        prot_dis = 1'b1;
        drive(1'b1, 1'b1, 20);
        chk("R2 fault cleared when disabled", int'(fault), 0);
        chk("R2 count held when disabled", int'(cnt), 0);
        prot_dis = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_count();
        t_short_limit();
        t_long_limit();
        t_short_window();
        t_long_window();
        t_latch_and_disable();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule